// File: doc/BRIEF.md
# Byte-Burst Load/Store Sequencer

This block is the memory stage of a small core. It takes one burst instruction at a time: a start byte address, a byte count from 1 to 124, and a direction (load or store). It breaks that instruction into beats on a 4-byte-wide local bus, one beat for each 32-bit word the byte range touches. Every beat carries the word address and a 4-bit lane strobe, so the first and last beats can be partial. Stores send the packed source bytes out on the matching lanes. Loads gather the returned lanes into a destination image that starts at byte 0, whatever the start offset was.

Stores are posted. The instruction ends as soon as the last beat has been handed to the write buffer. Loads from local data memory carry a fixed start-up latency: three clocks to the first word, then one more clock per further word. A wait input from the bus arbiter freezes the sequencer on the current beat, and every wait cycle adds to the count. When the instruction ends, the block gives a one-cycle done pulse together with the number of clocks the instruction occupied.

Top module: `burst_lsu`

## Requirements
- R1: After reset, busy_o, done_o and bus_req_o are 0 and cycles_o is 0.
- R2: A request issues B = floor((addr mod 4 + len + 3) / 4) beats, one per clock that wait_i is low. Their bus_addr_o values run consecutively upward from addr / 4. The beat count therefore grows by one when an access crosses an extra 4-byte boundary: a 2-byte access at offset 0 or 2 takes 1 beat, and at offset 3 it takes 2.
- R3: Bit l of bus_be_o (lane l, byte address bits [1:0] = l) is 1 exactly when that byte address lies in [addr, addr + len).
- R4: On a store beat, bus_we_o is 1. Each enabled lane carries store byte (byte address - addr), where store byte i is st_data_i[8i+7:8i]. Disabled lanes are 0.
- R5: A store occupies B clocks plus the number of wait cycles. done_o pulses in the clock after the last beat is accepted, and cycles_o shows the count in that same clock.
- R6: A load occupies B + 2 clocks plus the number of wait cycles (a 16-byte aligned load takes 6). done_o pulses in the clock after that.
- R7: For a load, bus_rdata_i is sampled one clock after a beat is accepted. When done_o pulses, ld_data_o byte i holds memory byte addr + i for i < len, and 0 for i >= len.
- R8: While bus_req_o and wait_i are both 1, the beat is held: address, strobes and write data do not change. No beat is lost or repeated.
- R9: A req_i while busy_o is 1 is ignored. It starts no beats and raises no extra done_o.
- R10: done_o lasts one clock, and cycles_o holds its value until the next done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a burst when idle |
| store_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | AW | Start byte address |
| len_i | input | $clog2(MAX_BYTES+1) | Byte count, 1..MAX_BYTES |
| st_data_i | input | MAX_BYTES*8 | Packed store bytes, byte 0 first |
| wait_i | input | 1 | Arbitration stall, holds the current beat |
| busy_o | output | 1 | A burst is in progress |
| bus_req_o | output | 1 | Beat valid on the local bus |
| bus_we_o | output | 1 | Beat is a write |
| bus_addr_o | output | AW-2 | Word address of the beat |
| bus_be_o | output | 4 | Lane strobes |
| bus_wdata_o | output | 32 | Write data lanes |
| bus_rdata_i | input | 32 | Read data, one clock after acceptance |
| done_o | output | 1 | Instruction finished, one-cycle pulse |
| cycles_o | output | CW | Clocks the instruction occupied |
| ld_data_o | output | MAX_BYTES*8 | Packed load result |

## Verification
The bench targets these corner cases:
- **Start offset.** It uses short accesses at offsets 2 and 3 and single bytes in the top lane. A wrong beat count from the offset would show up as a missing or extra beat. A strobe mask off by one lane would enable a byte outside the range.
- **Maximum lengths.** It runs 124-byte bursts, aligned and misaligned. These catch counter truncation and a final beat with the wrong strobes.
- **Wait patterns.** It applies periodic and long wait runs. A design that advances while stalled would skip a beat or change its address. A design that does not add wait cycles would report too few clocks.
- **Rejected requests.** It sends requests while the block is busy. A design that accepted them would produce stray beats or a second done pulse.
- **Load packing.** It checks load results for correct packing from byte 0 and for zeroed bytes past the end.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_BEAT,
    ST_TAIL
  } lsu_state_e;
endpackage

// File: rtl/lsu_beat_gen.sv
module lsu_beat_gen #(
  parameter int AW = 16,
  parameter int NB = 124,
  parameter int LW = 7,
  parameter int BW = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [LW-1:0]          len_i,
  input  logic                   adv_i,
  input  logic                   active_i,
  output logic [AW-3:0]          waddr_o,
  output logic [3:0]             be_o,
  output logic [3:0][LW-1:0]     lane_idx_o,
  output logic                   last_o
);
  localparam int SW = LW + 2;

  logic [AW-3:0] base_q;
  logic [1:0]    off_q;
  logic [LW-1:0] len_q;
  logic [BW-1:0] nbeats_q, beat_q;
  logic [SW-1:0] span;

  assign span = SW'(addr_i[1:0]) + SW'(len_i) + SW'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      off_q    <= '0;
      len_q    <= '0;
      nbeats_q <= '0;
      beat_q   <= '0;
    end else if (start_i) begin
      base_q   <= addr_i[AW-1:2];
      off_q    <= addr_i[1:0];
      len_q    <= len_i;
      nbeats_q <= BW'(span >> 2);
      beat_q   <= '0;
    end else if (adv_i) begin
      beat_q   <= beat_q + BW'(1);
    end
  end

  assign waddr_o = base_q + (AW-2)'(beat_q);
  assign last_o  = (beat_q == nbeats_q - BW'(1));

  for (genvar l = 0; l < 4; l++) begin : g_lane
    int pos, rel;
    always_comb begin
      pos           = int'(beat_q) * 4 + l;
      rel           = pos - int'(off_q);
      be_o[l]       = (rel >= 0) && (rel < int'(len_q));
      lane_idx_o[l] = LW'(rel);
    end
  end

  p_beat_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (beat_q < nbeats_q));

  p_addr_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !last_o) |=> (active_i && waddr_o == $past(waddr_o) + 1'b1));
endmodule

// File: rtl/lsu_ld_pack.sv
module lsu_ld_pack #(
  parameter int NB = 124,
  parameter int LW = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               cap_i,
  input  logic [3:0]         be_i,
  input  logic [3:0][LW-1:0] lane_idx_i,
  input  logic [31:0]        rdata_i,
  output logic [NB*8-1:0]    data_o
);
  logic [NB-1:0][7:0] buf_q;
  logic               pend_q;
  logic [3:0]         pend_be_q;
  logic [3:0][LW-1:0] pend_idx_q;

  // Data returns one clock after the beat is accepted.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q      <= '0;
      pend_q     <= 1'b0;
      pend_be_q  <= '0;
      pend_idx_q <= '0;
    end else begin
      pend_q     <= cap_i;
      pend_be_q  <= be_i;
      pend_idx_q <= lane_idx_i;
      if (clear_i) begin
        buf_q <= '0;
      end else if (pend_q) begin
        for (int l = 0; l < 4; l++) begin
          if (pend_be_q[l] && int'(pend_idx_q[l]) < NB)
            buf_q[pend_idx_q[l]] <= rdata_i[8*l +: 8];
        end
      end
    end
  end

  assign data_o = buf_q;

  p_cap_lane_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> (be_i != 4'b0));
endmodule

// File: rtl/burst_lsu.sv
module burst_lsu #(
  parameter int AW        = 16,
  parameter int MAX_BYTES = 124,
  parameter int LD_LAT    = 3,
  parameter int CW        = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_i,
  input  logic                           store_i,
  input  logic [AW-1:0]                  addr_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0] len_i,
  input  logic [MAX_BYTES*8-1:0]         st_data_i,
  input  logic                           wait_i,
  output logic                           busy_o,
  output logic                           bus_req_o,
  output logic                           bus_we_o,
  output logic [AW-3:0]                  bus_addr_o,
  output logic [3:0]                     bus_be_o,
  output logic [31:0]                    bus_wdata_o,
  input  logic [31:0]                    bus_rdata_i,
  output logic                           done_o,
  output logic [CW-1:0]                  cycles_o,
  output logic [MAX_BYTES*8-1:0]         ld_data_o
);
  import lsu_pkg::*;

  localparam int LW       = $clog2(MAX_BYTES + 1);
  localparam int BEAT_MAX = (MAX_BYTES + 6) / 4;
  localparam int BW       = $clog2(BEAT_MAX + 1);
  localparam int TAIL_N   = LD_LAT - 1;
  localparam int TW       = (TAIL_N > 1) ? $clog2(TAIL_N) : 1;

  lsu_state_e         state_q;
  logic               we_q, done_q;
  logic [CW-1:0]      cyc_q, cycles_q;
  logic [TW-1:0]      tail_q;
  logic [MAX_BYTES-1:0][7:0] st_q;

  logic               start, adv, last;
  logic [3:0]         be;
  logic [3:0][LW-1:0] lane_idx;

  assign start = (state_q == ST_IDLE) && req_i;
  assign adv   = (state_q == ST_BEAT) && !wait_i;

  lsu_beat_gen #(.AW(AW), .NB(MAX_BYTES), .LW(LW), .BW(BW)) u_beat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (addr_i),
    .len_i      (len_i),
    .adv_i      (adv),
    .active_i   (bus_req_o),
    .waddr_o    (bus_addr_o),
    .be_o       (be),
    .lane_idx_o (lane_idx),
    .last_o     (last)
  );

  lsu_ld_pack #(.NB(MAX_BYTES), .LW(LW)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (start),
    .cap_i      (adv && !we_q),
    .be_i       (be),
    .lane_idx_i (lane_idx),
    .rdata_i    (bus_rdata_i),
    .data_o     (ld_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      done_q   <= 1'b0;
      cyc_q    <= '0;
      cycles_q <= '0;
      tail_q   <= '0;
      st_q     <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_BEAT;
          we_q    <= store_i;
          st_q    <= st_data_i;
          cyc_q   <= '0;
        end
        ST_BEAT: begin
          cyc_q <= cyc_q + CW'(1);
          if (adv && last) begin
            if (we_q) begin
              state_q  <= ST_IDLE;
              done_q   <= 1'b1;
              cycles_q <= cyc_q + CW'(1);
            end else begin
              state_q <= ST_TAIL;
              tail_q  <= '0;
            end
          end
        end
        ST_TAIL: begin
          cyc_q  <= cyc_q + CW'(1);
          tail_q <= tail_q + TW'(1);
          if (tail_q == TW'(TAIL_N - 1)) begin
            state_q  <= ST_IDLE;
            done_q   <= 1'b1;
            cycles_q <= cyc_q + CW'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_wd
    assign bus_wdata_o[8*l +: 8] = be[l] ? st_q[lane_idx[l]] : 8'h00;
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign bus_req_o = (state_q == ST_BEAT);
  assign bus_we_o  = bus_req_o && we_q;
  assign bus_be_o  = be;
  assign done_o    = done_q;
  assign cycles_o  = cycles_q;

  p_be_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_be_o != 4'b0));

  p_hold_on_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && wait_i) |=> (bus_req_o && $stable(bus_addr_o) &&
                               $stable(bus_be_o) && $stable(bus_wdata_o)));

  p_store_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !wait_i && last) |=> done_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && $stable(cycles_o)));

  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/burst_lsu_test.sv
`timescale 1ns/1ps
module burst_lsu_test;
  localparam int NB = 124;
  localparam int DW = NB * 8;

  typedef struct packed {
    logic [13:0] wa;
    logic [3:0]  be;
    logic        we;
    logic [31:0] wd;
  } beat_t;

  typedef struct packed {
    logic        ld;
    logic [15:0] a;
    logic [6:0]  n;
    logic [15:0] base;
    logic        poke;
  } res_t;

  logic          clk = 1'b0;
  logic          rst_ni, req_i, store_i, wait_i;
  logic [15:0]   addr_i;
  logic [6:0]    len_i;
  logic [DW-1:0] st_data_i;
  logic          busy_o, bus_req_o, bus_we_o, done_o;
  logic [13:0]   bus_addr_o;
  logic [3:0]    bus_be_o;
  logic [31:0]   bus_wdata_o, bus_rdata_i;
  logic [15:0]   cycles_o;
  logic [DW-1:0] ld_data_o;

  burst_lsu uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .store_i(store_i),
    .addr_i(addr_i), .len_i(len_i), .st_data_i(st_data_i), .wait_i(wait_i),
    .busy_o(busy_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_be_o(bus_be_o), .bus_wdata_o(bus_wdata_o),
    .bus_rdata_i(bus_rdata_i), .done_o(done_o), .cycles_o(cycles_o),
    .ld_data_o(ld_data_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int stall_mode = 0, tick = 0, stalls = 0;
  beat_t bq[$];
  res_t  rq[$];
  logic        pend_v = 1'b0;
  logic [13:0] pend_a = '0;
  logic        prev_done = 1'b0;
  logic [15:0] prev_cyc = '0;

  function automatic logic [7:0] mbyte(logic [15:0] a);
    return (a[7:0] * 8'd5 + a[15:8]) ^ 8'ha5;
  endfunction

  function automatic logic [31:0] mword(logic [13:0] w);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[8*l +: 8] = mbyte({w, 2'(l)});
    return r;
  endfunction

  task automatic finish_sim();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Bus model, stall generator and scoreboard monitor
  always @(negedge clk) begin
    logic w;
    bus_rdata_i = pend_v ? mword(pend_a) : 32'hdead_beef;
    tick++;
    case (stall_mode)
      1:       w = (tick % 3) == 1;
      2:       w = (tick % 8) < 3;
      default: w = 1'b0;
    endcase
    wait_i = w;
    if (rst_ni) begin
      if (prev_done) begin
        checks++;
        if (done_o !== 1'b0 || cycles_o !== prev_cyc) begin
          fails++;
          $display("FAIL R10 done=%b cycles=%0d expected done=0 cycles=%0d",
                   done_o, cycles_o, prev_cyc);
        end
      end
      prev_done = done_o;
      prev_cyc  = cycles_o;
      if (bus_req_o && w) stalls++;
      if (bus_req_o && !w) begin
        beat_t b;
        checks++;
        if (bq.size() == 0) begin
          fails++;
          $display("FAIL R2/R9 unexpected beat addr=%h expected none", bus_addr_o);
        end else begin
          b = bq.pop_front();
          if (bus_addr_o !== b.wa || bus_be_o !== b.be || bus_we_o !== b.we ||
              (b.we && bus_wdata_o !== b.wd)) begin
            fails++;
            $display("FAIL R2/R3/R4 beat addr=%h be=%b we=%b wd=%h expected addr=%h be=%b we=%b wd=%h",
                     bus_addr_o, bus_be_o, bus_we_o, bus_wdata_o, b.wa, b.be, b.we, b.wd);
          end
        end
      end
      pend_v = bus_req_o && !w;
      pend_a = bus_addr_o;
      if (done_o) begin
        res_t r;
        int exp_c;
        checks++;
        if (rq.size() == 0) begin
          fails++;
          $display("FAIL R9 unexpected done cycles=%0d expected no done", cycles_o);
        end else begin
          r = rq.pop_front();
          exp_c = int'(r.base) + stalls;
          if (int'(cycles_o) != exp_c) begin
            fails++;
            $display("FAIL %s cycles=%0d expected %0d", r.ld ? "R6" : "R5", cycles_o, exp_c);
          end
          checks++;
          if (bq.size() != 0) begin
            fails++;
            $display("FAIL %s beats left=%0d expected 0", stalls > 0 ? "R8" : "R2", bq.size());
          end
          if (r.ld) begin
            logic [DW-1:0] e;
            e = '0;
            for (int i = 0; i < int'(r.n); i++) e[8*i +: 8] = mbyte(r.a + 16'(i));
            checks++;
            if (ld_data_o !== e) begin
              fails++;
              $display("FAIL R7 ld_data=%h expected %h", ld_data_o, e);
            end
          end
        end
        stalls = 0;
      end
    end
  end

  task automatic run_op(input logic st, input logic [15:0] a, input int n,
                        input int mode, input logic poke);
    logic [DW-1:0] sd;
    beat_t tmp[0:33];
    res_t  r;
    int first, nb, k;
    for (int i = 0; i < NB; i++) sd[8*i +: 8] = 8'(a) + 8'(i * 3) + 8'h11;
    first = int'(a) / 4;
    nb = ((int'(a) + n - 1) / 4) - first + 1;
    for (int j = 0; j < nb; j++) begin
      tmp[j].wa = 14'(first + j);
      tmp[j].be = '0;
      tmp[j].we = st;
      tmp[j].wd = '0;
    end
    for (int i = 0; i < n; i++) begin
      k = (int'(a) + i) / 4 - first;
      tmp[k].be[(int'(a) + i) % 4] = 1'b1;
      tmp[k].wd[8*((int'(a) + i) % 4) +: 8] = sd[8*i +: 8];
    end
    for (int j = 0; j < nb; j++) bq.push_back(tmp[j]);
    r.ld = !st; r.a = a; r.n = 7'(n); r.base = 16'(nb + (st ? 0 : 2)); r.poke = poke;
    rq.push_back(r);
    @(negedge clk);
    stall_mode = mode;
    req_i = 1'b1; store_i = st; addr_i = a; len_i = 7'(n); st_data_i = sd;
    @(negedge clk);
    if (poke) begin
      // R9: request while busy must be dropped
      store_i = !st; addr_i = a + 16'd5; len_i = 7'd3; st_data_i = ~sd;
      @(negedge clk);
    end
    req_i = 1'b0;
    while (rq.size() != 0) @(negedge clk);
    stall_mode = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired expected completion");
    finish_sim();
  end

  initial begin
    rst_ni = 1'b0; req_i = 1'b0; store_i = 1'b0; addr_i = '0; len_i = '0;
    st_data_i = '0; wait_i = 1'b0; bus_rdata_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (busy_o !== 1'b0 || done_o !== 1'b0 || bus_req_o !== 1'b0 || cycles_o !== 16'd0) begin
      fails++;
      $display("FAIL R1 busy=%b done=%b req=%b cycles=%0d expected 0 0 0 0",
               busy_o, done_o, bus_req_o, cycles_o);
    end
    run_op(1'b1, 16'h0100, 16, 0, 1'b0);   // R5 aligned 4 words
    run_op(1'b1, 16'h0102, 2, 0, 1'b0);    // R2 offset 2, one beat
    run_op(1'b1, 16'h0103, 2, 0, 1'b0);    // R2 offset 3, two beats
    run_op(1'b1, 16'h0203, 1, 0, 1'b0);    // R3 top lane only
    run_op(1'b0, 16'h0040, 16, 0, 1'b0);   // R6 six clocks
    run_op(1'b0, 16'h0103, 2, 0, 1'b0);    // R7 split load
    run_op(1'b0, 16'h0301, 124, 0, 1'b0);  // R7 max misaligned
    run_op(1'b1, 16'h0400, 124, 0, 1'b0);  // R4 max aligned
    run_op(1'b1, 16'h0001, 7, 1, 1'b1);    // R8 R9
    run_op(1'b0, 16'h0502, 30, 2, 1'b1);   // R8 R9
    run_op(1'b1, 16'h0613, 61, 2, 1'b0);   // R8
    run_op(1'b0, 16'h0700, 1, 1, 1'b1);
    run_op(1'b0, 16'h0806, 124, 1, 1'b0);
    repeat (5) @(negedge clk);
    checks++;
    if (busy_o !== 1'b0 || bq.size() != 0) begin
      fails++;
      $display("FAIL R9 busy=%b beats_left=%0d expected 0 0", busy_o, bq.size());
    end
    finish_sim();
  end
endmodule